// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Front End

This block is the digital front end of a two-channel, 12-bit serial-input converter. A host addresses it through three wires: an active-low select, a serial clock and a data line. While the select is low, each rising edge of the serial clock moves one data bit into a 24-bit frame register. The channel B code is sent first, then the channel A code, each with its most significant bit first. Two 12-bit output latches hold the codes that the converters use, and both are presented as parallel outputs.

A serial echo output returns every bit 24 serial clocks after it went in. It changes on the falling edge of the serial clock. Several devices can therefore be chained, and a host can read back the frame it wrote last. While the select is high, the echo output is released: its enable is low and the data pin reads as a pulled-up 1. The latch transfer is level-gated. Both latches copy the frame register whenever the select is high and the active-low load strobe is low. If the strobe is tied low, the latches update when the select rises (three-wire use). If the strobe is driven, the latches update when it falls with the select high (four-wire use).

All serial inputs pass through two-flop synchronizers into the system clock domain. The edges are detected there. A controller with three states decides when bits shift and when the latches load:
- ST_IDLE: deselected, no load. It moves to ST_SHIFT when the select goes low, and to ST_LOAD when the strobe goes low.
- ST_SHIFT: selected. It moves to ST_LOAD when the select rises with the strobe low, and to ST_IDLE when the select rises with the strobe high.
- ST_LOAD: deselected with the strobe low, and the latches copy the frame on every cycle. It moves to ST_SHIFT when the select goes low, and to ST_IDLE when the strobe rises.

Top module: `dual_dac_frontend`

## Requirements
- R1: After reset both channel latches read 0, the echo enable is 0 and the echo pin reads 1.
- R2: A frame is shifted in most significant bit first. After a load, frame bits [23:12] (the first 12 bits sent) appear on channel B and bits [11:0] (the last 12 bits sent) appear on channel A.
- R3: Serial clock edges and data seen while the select is high do not change the frame register. A later load returns the frame written before them.
- R4: While selected, the echo pin changes only after a falling serial clock edge. After the k-th falling edge of a frame it shows bit 24-k of the previous frame, so the previous frame is read back most significant bit first.
- R5: While the select is low the echo enable is 1. While the select is high the enable is 0 and the echo pin reads 1.
- R6: With the strobe held low, both latches take the new frame when the select rises.
- R7: With the strobe high, a rising select leaves the latches unchanged. A later falling strobe while the select is high loads both latches.
- R8: A low strobe while the select is low does not load the latches.
- R9: A frame longer or shorter than 24 clocks is not rejected. The latches take the last 24 bits shifted, with earlier frame bits moving up to fill a short frame.
- R10: Outside a load condition both latch outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset (power-on clear) |
| ser_clk | input | 1 | Serial clock |
| ser_sel_n | input | 1 | Active-low select |
| ser_din | input | 1 | Serial data in |
| load_n | input | 1 | Active-low latch load strobe, asynchronous to the serial clock |
| ser_dout | output | 1 | Echo data; reads 1 when released |
| ser_dout_oe | output | 1 | Echo drive enable (high while selected) |
| code_a | output | 12 | Channel A latch value |
| code_b | output | 12 | Channel B latch value |

## Verification
The in-line assertions check on every cycle that the frame register moves only on a qualified rising edge and that the echo register moves only on a falling edge or when the select is taken. They also check that the controller enters ST_LOAD only after the select was seen high and the strobe low, that a load copies the frame with channel B in the upper half, and that the latches hold outside a load. Only the bench scenarios can show the behaviour seen from outside:
- the bit order of a whole frame and the 24-clock echo of the previous frame;
- the difference between three-wire and four-wire updates;
- that clocks received while deselected are ignored;
- how frames of the wrong length land in the latches.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } fe_state_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int NSIG   = 4,
    parameter int STAGES = 2,
    parameter logic [NSIG-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] async_in,
    output logic [NSIG-1:0] sync_out,
    output logic [NSIG-1:0] sync_dly
);
    for (genvar s = 0; s < NSIG; s++) begin : g_sig
        logic [STAGES-1:0] chain;
        logic              dly;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[s]}};
                dly   <= RST_VAL[s];
            end else begin
                chain <= {chain[STAGES-2:0], async_in[s]};
                dly   <= chain[STAGES-1];
            end
        end
        assign sync_out[s] = chain[STAGES-1];
        assign sync_dly[s] = dly;
    end
endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
    import dacfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    input  logic load_s,
    input  logic sclk_s,
    input  logic sclk_d,
    output logic shift_pulse,
    output logic fall_pulse,
    output logic sel_entry,
    output logic latch_en,
    output logic out_en
);
    fe_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!sel_s) state_d = ST_SHIFT;
                      else if (!load_s) state_d = ST_LOAD;
            ST_SHIFT: if (sel_s) state_d = load_s ? ST_IDLE : ST_LOAD;
            ST_LOAD:  if (!sel_s) state_d = ST_SHIFT;
                      else if (load_s) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        shift_pulse = 1'b0;
        fall_pulse  = 1'b0;
        sel_entry   = 1'b0;
        latch_en    = 1'b0;
        out_en      = 1'b0;
        unique case (state_q)
            ST_IDLE:  sel_entry = !sel_s;
            ST_SHIFT: begin
                out_en      = 1'b1;
                shift_pulse = sclk_s & !sclk_d;
                fall_pulse  = !sclk_s & sclk_d;
            end
            ST_LOAD: begin
                latch_en  = 1'b1;
                sel_entry = !sel_s;
            end
            default: ;
        endcase
    end

    // R8: the load state is reached only after select high with strobe low
    assert_load_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> ($past(sel_s) && !$past(load_s)));
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_pulse,
    input  logic               fall_pulse,
    input  logic               sel_entry,
    input  logic               din_s,
    output logic [FRAME_W-1:0] frame,
    output logic               echo_bit
);
    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame    <= '0;
            hold_q   <= 1'b0;
            echo_bit <= 1'b0;
        end else begin
            if (shift_pulse) begin
                hold_q <= frame[FRAME_W-1];
                frame  <= {frame[FRAME_W-2:0], din_s};
            end
            if (sel_entry)       echo_bit <= frame[FRAME_W-1];
            else if (fall_pulse) echo_bit <= hold_q;
        end
    end

    // R3: the frame register moves only on a qualified rising edge
    assert_frame_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_pulse |=> $stable(frame));
    // R4: the echo register moves only on a falling edge or on select entry
    assert_echo_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_pulse || sel_entry) |=> $stable(echo_bit));
endmodule

// File: rtl/dacfe_latch.sv
module dacfe_latch #(
    parameter int CODE_W = 12,
    parameter int NCH    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  latch_en,
    input  logic [NCH*CODE_W-1:0] frame,
    output logic [NCH*CODE_W-1:0] codes
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        codes[c*CODE_W +: CODE_W] <= '0;
            else if (latch_en) codes[c*CODE_W +: CODE_W] <= frame[c*CODE_W +: CODE_W];
        end
    end

    // R2: a load copies the whole frame, upper half to the last channel
    assert_latch_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> (codes == $past(frame)));
    // R10: latches hold outside a load
    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(codes));
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend #(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sel_n,
    input  logic              ser_din,
    input  logic              load_n,
    output logic              ser_dout,
    output logic              ser_dout_oe,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    localparam int FRAME_W = 2 * CODE_W;

    logic [3:0]         raw, syn, dly;
    logic               shift_pulse, fall_pulse, sel_entry, latch_en, out_en, echo_bit;
    logic [FRAME_W-1:0] frame, codes;

    // order: {load_n, ser_sel_n, ser_clk, ser_din}
    assign raw = {load_n, ser_sel_n, ser_clk, ser_din};

    dacfe_sync #(.NSIG(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(raw), .sync_out(syn), .sync_dly(dly));

    dacfe_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_s(syn[2]), .load_s(syn[3]),
        .sclk_s(syn[1]), .sclk_d(dly[1]), .shift_pulse(shift_pulse),
        .fall_pulse(fall_pulse), .sel_entry(sel_entry), .latch_en(latch_en),
        .out_en(out_en));

    dacfe_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_pulse(shift_pulse), .fall_pulse(fall_pulse),
        .sel_entry(sel_entry), .din_s(syn[0]), .frame(frame), .echo_bit(echo_bit));

    dacfe_latch #(.CODE_W(CODE_W), .NCH(2)) u_latch (
        .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .frame(frame), .codes(codes));

    assign code_a      = codes[CODE_W-1:0];
    assign code_b      = codes[FRAME_W-1:CODE_W];
    assign ser_dout_oe = out_en;
    assign ser_dout    = out_en ? echo_bit : 1'b1;
endmodule

// File: tb/dual_dac_frontend_tb_top.sv
module dual_dac_frontend_tb_top;
    logic clk = 0, rst_n = 0;
    logic ser_clk = 0, ser_sel_n = 1, ser_din = 0, load_n = 1;
    logic ser_dout, ser_dout_oe;
    logic [11:0] code_a, code_b;
    int total = 0, bad = 0;
    localparam int HP = 8;

    always #5 clk = ~clk;

    dual_dac_frontend dut_i (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk),
        .ser_sel_n(ser_sel_n), .ser_din(ser_din), .load_n(load_n),
        .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe), .code_a(code_a), .code_b(code_b));

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // shift nbits of val, MSB first; optionally compare echo with prev frame
    task automatic shift_bits(input logic [31:0] val, input int nbits,
                              input bit chk_echo, input logic [23:0] prev);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_din = val[i];
            wcyc(HP);
            ser_clk = 1;
            wcyc(HP);
            ser_clk = 0;
            wcyc(6);
            if (chk_echo) check("R4 echo", ser_dout, prev[i]);
            wcyc(HP - 6);
        end
    endtask

    task automatic frame(input logic [31:0] val, input int nbits,
                         input bit chk_echo, input logic [23:0] prev);
        ser_sel_n = 0;
        wcyc(HP);
        check("R5 oe selected", ser_dout_oe, 1);
        shift_bits(val, nbits, chk_echo, prev);
        ser_sel_n = 1;
        wcyc(HP);
    endtask

    task automatic t_reset();
        check("R1 code_a", code_a, 0);
        check("R1 code_b", code_b, 0);
        check("R1 oe", ser_dout_oe, 0);
        check("R1 dout", ser_dout, 1);
    endtask

    task automatic t_three_wire();
        load_n = 0;
        frame(32'hABC123, 24, 0, 0);
        check("R2 R6 code_b", code_b, 12'hABC);
        check("R2 R6 code_a", code_a, 12'h123);
        check("R5 released oe", ser_dout_oe, 0);
        check("R5 released dout", ser_dout, 1);
        frame(32'h5A50FF, 24, 0, 0);
        check("R6 code_b", code_b, 12'h5A5);
        check("R6 code_a", code_a, 12'h0FF);
    endtask

    task automatic t_readback();
        load_n = 0;
        frame(32'h9C36E1, 24, 0, 0);
        frame(32'h2468AC, 24, 1, 24'h9C36E1);
        check("R4 new frame loaded", {code_b, code_a}, 24'h2468AC);
    endtask

    task automatic t_four_wire();
        load_n = 1;
        wcyc(HP);
        frame(32'h777888, 24, 0, 0);
        check("R7 R10 no update on select rise", {code_b, code_a}, 24'h2468AC);
        load_n = 0;
        wcyc(HP);
        check("R7 update on strobe", {code_b, code_a}, 24'h777888);
        load_n = 1;
        wcyc(HP);
    endtask

    task automatic t_load_while_selected();
        ser_sel_n = 0;
        wcyc(HP);
        shift_bits(32'h13579B, 24, 0, 0);
        load_n = 0;
        wcyc(HP);
        check("R8 no load while selected", {code_b, code_a}, 24'h777888);
        load_n = 1;
        wcyc(HP);
        ser_sel_n = 1;
        wcyc(HP);
        check("R8 R10 hold", {code_b, code_a}, 24'h777888);
        load_n = 0;
        wcyc(HP);
        check("R8 later load", {code_b, code_a}, 24'h13579B);
        load_n = 1;
        wcyc(HP);
    endtask

    task automatic t_ignored_clocks();
        frame(32'hC0FFEE, 24, 0, 0);
        for (int i = 0; i < 10; i++) begin
            ser_din = i[0];
            wcyc(HP); ser_clk = 1;
            wcyc(HP); ser_clk = 0;
        end
        check("R3 R5 dout released", ser_dout, 1);
        load_n = 0;
        wcyc(HP);
        check("R3 frame kept", {code_b, code_a}, 24'hC0FFEE);
        load_n = 1;
        wcyc(HP);
    endtask

    task automatic t_odd_length();
        load_n = 0;
        frame(32'hF123456A, 28, 0, 0);
        check("R9 long frame", {code_b, code_a}, 24'h23456A);
        frame(32'h0000005C, 8, 0, 0);
        check("R9 short frame", {code_b, code_a}, 24'h456A5C);
        load_n = 1;
    endtask

    initial begin
        wcyc(4);
        rst_n = 1;
        wcyc(4);
        t_reset();
        t_three_wire();
        t_readback();
        t_four_wire();
        t_load_while_selected();
        t_ignored_clocks();
        t_odd_length();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule